// File: doc/BRIEF.md
# Switch-Entry Unsigned Arithmetic Calculator

This block is a small synchronous calculator. It takes two 16-bit unsigned operands from one shared bank of toggle switches, one operand at a time. Each operand is captured when its own push-button is pressed. A third button adds the two operands, or multiplies them when a mode switch is up. A fourth button subtracts the second operand from the first.

The result appears on a 16-bit LED bank. While no result is on show, each LED follows the switch below it. The result stays on the LEDs after its button is released, and pressing either capture button returns the LEDs to following the switches. A flag output reports a lost carry, a borrow, or a product too wide for 16 bits.

All four buttons are active low and asynchronous. Each passes through a two-stage synchroniser and a debounce counter, and triggers once on the press edge of its debounced level.

Top module: `swcalc_top`

## Requirements
- R1: After reset both operands are zero, the flag is 0, and the LEDs follow the switches. An add pressed straight after reset therefore shows 0 with the flag at 0.
- R2: While no result is shown, `led_o` equals the value `sw_i` had one clock earlier.
- R3: A press of `key_n_i[3]` stores `sw_i` as operand A. A press of `key_n_i[2]` stores `sw_i` as operand B. A later capture overwrites the stored value.
- R4: A press of `key_n_i[1]` with `mode_i`=0 shows (A+B) mod 65536. `ovf_o` is 1 exactly when the sum exceeds 65535.
- R5: A press of `key_n_i[1]` with `mode_i`=1 shows the low 16 bits of A*B. `ovf_o` is 1 exactly when the 32-bit product is above 65535.
- R6: A press of `key_n_i[0]` shows (A-B) mod 65536. `ovf_o` is 1 exactly when A<B.
- R7: A shown result and its flag stay unchanged after the button is released and while the switches change.
- R8: A capture press with no operation in the same cycle returns the LEDs to following the switches and clears `ovf_o`.
- R9: A button low for fewer than `DEBOUNCE_CYCLES` consecutive synchronised samples has no effect. A held button acts only once.
- R10: If the add/multiply and subtract buttons fire in the same cycle, add/multiply wins. If a capture and an operation fire in the same cycle, the operation uses the operands held before that cycle and its result is shown, and the capture still stores the switch word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sw_i | input | 16 | Operand switches, 1 = up |
| mode_i | input | 1 | 1 = button 1 multiplies, 0 = adds |
| key_n_i | input | 4 | Active-low buttons: [3] capture A, [2] capture B, [1] add/multiply, [0] subtract |
| led_o | output | 16 | Switch mirror or latched result |
| ovf_o | output | 1 | Carry, borrow or wide-product flag for the shown result |

## Verification
Two buttons can produce debounced press pulses in the same clock cycle. This happens for a capture and an operation, and also for the two operation buttons. The bench provokes both cases by driving the two buttons low on the same clock edge. Because every button passes through identical synchroniser and debounce stages, the two pulses then fall in the same cycle. The bench judges the outcome at the ports:
- For add and subtract together, the shown value must be the sum.
- For a capture together with an operation, the shown value must use the earlier operand. A later subtraction must then reveal that the capture still stored the new switch word.

// File: rtl/swcalc_pkg.sv
package swcalc_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2
  } calc_op_e;

  localparam int unsigned KEY_SUB  = 0;
  localparam int unsigned KEY_ADD  = 1;
  localparam int unsigned KEY_CAPB = 2;
  localparam int unsigned KEY_CAPA = 3;
  localparam int unsigned NUM_KEYS = 4;
endpackage

// File: rtl/swcalc_debounce.sv
module swcalc_debounce #(
  parameter int unsigned STABLE_CYCLES = 250000
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic key_n_i,
  output logic press_o
);
  localparam int unsigned CNT_W = $clog2(STABLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYCLES - 1);

  logic             meta_q, sync_q, level_q;
  logic [CNT_W-1:0] cnt_q;
  logic             press_q;
  logic             differs, settle;

  assign differs = (sync_q != level_q);
  assign settle  = differs && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= key_n_i;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
      press_q <= 1'b0;
    end else begin
      press_q <= settle && !sync_q;
      if (settle) begin
        level_q <= sync_q;
        cnt_q   <= '0;
      end else if (differs) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign press_o = press_q;

  // R9
  press_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    press_q |=> !press_q);
  // R9
  press_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    press_q |-> !level_q);
endmodule

// File: rtl/swcalc_operands.sv
module swcalc_operands #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] sw_i,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  output logic [DATA_W-1:0] opa_o,
  output logic [DATA_W-1:0] opb_o
);
  logic [DATA_W-1:0] opa_q, opb_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      if (cap_a_i) opa_q <= sw_i;
      if (cap_b_i) opb_q <= sw_i;
    end
  end

  assign opa_o = opa_q;
  assign opb_o = opb_q;

  // R3
  opa_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !cap_a_i |=> $stable(opa_q));
  // R3
  opb_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !cap_b_i |=> $stable(opb_q));
endmodule

// File: rtl/swcalc_alu.sv
module swcalc_alu
  import swcalc_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              fire_i,
  input  calc_op_e          op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o,
  output logic              ovf_o
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [DATA_W:0]   sum_w, dif_w;
  logic [PROD_W-1:0] prod_w;
  logic [DATA_W-1:0] res_d, res_q;
  logic              ovf_d, ovf_q;

  always_comb begin
    sum_w  = {1'b0, a_i} + {1'b0, b_i};
    dif_w  = {1'b0, a_i} - {1'b0, b_i};
    prod_w = PROD_W'(a_i) * PROD_W'(b_i);
    unique case (op_i)
      OP_SUB: begin
        res_d = dif_w[DATA_W-1:0];
        ovf_d = dif_w[DATA_W];
      end
      OP_MUL: begin
        res_d = prod_w[DATA_W-1:0];
        ovf_d = |prod_w[PROD_W-1:DATA_W];
      end
      default: begin
        res_d = sum_w[DATA_W-1:0];
        ovf_d = sum_w[DATA_W];
      end
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (fire_i) begin
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  assign res_o = res_q;
  assign ovf_o = ovf_q;

  // R4
  add_carry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fire_i && op_i == OP_ADD) |=> (ovf_q == (res_q < $past(a_i))));
  // R6
  sub_borrow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fire_i && op_i == OP_SUB) |=> (ovf_q == ($past(a_i) < $past(b_i))));
  // R5
  mul_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (fire_i && op_i == OP_MUL && a_i == '0) |=> (res_q == '0 && !ovf_q));
  // R7
  res_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !fire_i |=> ($stable(res_q) && $stable(ovf_q)));
endmodule

// File: rtl/swcalc_top.sv
module swcalc_top
  import swcalc_pkg::*;
#(
  parameter int unsigned DATA_W          = 16,
  parameter int unsigned DEBOUNCE_CYCLES = 250000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [DATA_W-1:0] sw_i,
  input  logic              mode_i,
  input  logic [3:0]        key_n_i,
  output logic [DATA_W-1:0] led_o,
  output logic              ovf_o
);
  logic [NUM_KEYS-1:0] press;
  logic [DATA_W-1:0]   opa, opb, alu_res;
  logic                alu_ovf;
  logic                op_fire, any_cap;
  calc_op_e            op_sel;
  logic                show_q;
  logic [DATA_W-1:0]   led_q;
  logic                ovf_q;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    swcalc_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_db (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .key_n_i (key_n_i[k]),
      .press_o (press[k])
    );
  end

  swcalc_operands #(.DATA_W(DATA_W)) u_ops (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .sw_i    (sw_i),
    .cap_a_i (press[KEY_CAPA]),
    .cap_b_i (press[KEY_CAPB]),
    .opa_o   (opa),
    .opb_o   (opb)
  );

  // Add/multiply button has priority over subtract.
  always_comb begin
    op_fire = press[KEY_ADD] | press[KEY_SUB];
    any_cap = press[KEY_CAPA] | press[KEY_CAPB];
    if (press[KEY_ADD]) op_sel = mode_i ? OP_MUL : OP_ADD;
    else                op_sel = OP_SUB;
  end

  swcalc_alu #(.DATA_W(DATA_W)) u_alu (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .fire_i (op_fire),
    .op_i   (op_sel),
    .a_i    (opa),
    .b_i    (opb),
    .res_o  (alu_res),
    .ovf_o  (alu_ovf)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      show_q <= 1'b0;
      led_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (op_fire)      show_q <= 1'b1;
      else if (any_cap) show_q <= 1'b0;
      led_q <= show_q ? alu_res : sw_i;
      ovf_q <= show_q & alu_ovf;
    end
  end

  assign led_o = led_q;
  assign ovf_o = ovf_q;

  // R8
  cap_return_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (any_cap && !op_fire) |=> !show_q);
  // R10
  op_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    op_fire |=> show_q);
  // R7
  led_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (show_q && $past(show_q) && !$past(op_fire) && !op_fire && !any_cap)
      |=> ($stable(led_q) && $stable(ovf_q)));
endmodule

// File: tb/tb_swcalc_top.sv
`timescale 1ns/1ps
module tb_swcalc_top;
  localparam int unsigned W   = 16;
  localparam int unsigned DEB = 8;
  localparam int unsigned GAP = DEB + 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] sw;
  logic         mode;
  logic [3:0]   key_n;
  logic [W-1:0] led;
  logic         ovf;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  swcalc_top #(.DATA_W(W), .DEBOUNCE_CYCLES(DEB)) dut (
    .clk_i   (clk),
    .rst_i   (rst),
    .sw_i    (sw),
    .mode_i  (mode),
    .key_n_i (key_n),
    .led_o   (led),
    .ovf_o   (ovf)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic [3:0] mask);
    @(negedge clk);
    key_n = ~mask;
    idle(GAP);
    key_n = 4'hF;
    idle(GAP);
  endtask

  task automatic load(input logic [W-1:0] a, input logic [W-1:0] b);
    sw = a; press(4'b1000);
    sw = b; press(4'b0100);
  endtask

  task automatic t_reset;
    rst = 1'b1; sw = 16'hA5A5; mode = 1'b0; key_n = 4'hF;
    idle(4);
    rst = 1'b0;
    idle(2);
    check("R1 led mirror", {1'b0, led}, {1'b0, 16'hA5A5});
    check("R1 flag", {16'h0, ovf}, 17'h0);
    press(4'b0010);
    check("R1 zero operands sum", {ovf, led}, 17'h0);
    sw = 16'h0F0F; press(4'b1000);
  endtask

  task automatic t_mirror;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      sw = 16'h1111 * (i + 3);
      @(negedge clk);
      check("R2 mirror", {1'b0, led}, {1'b0, 16'h1111 * (i + 3)});
    end
  endtask

  task automatic t_add;
    mode = 1'b0;
    load(16'd1234, 16'd4321); press(4'b0010);
    check("R4 sum", {ovf, led}, {1'b0, 16'd5555});
    load(16'hFFFF, 16'd1); press(4'b0010);
    check("R4 carry", {ovf, led}, {1'b1, 16'd0});
    load(16'd7, 16'd9); load(16'd20, 16'd22); press(4'b0010);
    check("R3 overwrite", {ovf, led}, {1'b0, 16'd42});
  endtask

  task automatic t_mul;
    mode = 1'b1;
    load(16'd255, 16'd257); press(4'b0010);
    check("R5 product fits", {ovf, led}, {1'b0, 16'd65535});
    load(16'd300, 16'd300); press(4'b0010);
    check("R5 product wide", {ovf, led}, {1'b1, 16'h5F90});
    mode = 1'b0;
  endtask

  task automatic t_sub;
    load(16'd5000, 16'd1234); press(4'b0001);
    check("R6 difference", {ovf, led}, {1'b0, 16'd3766});
    load(16'd0, 16'd1); press(4'b0001);
    check("R6 borrow", {ovf, led}, {1'b1, 16'hFFFF});
  endtask

  task automatic t_hold_and_return;
    sw = 16'h1357; idle(5);
    check("R7 result held", {ovf, led}, {1'b1, 16'hFFFF});
    sw = 16'h2468; press(4'b0100);
    check("R8 mirror again", {ovf, led}, {1'b0, 16'h2468});
  endtask

  task automatic t_glitch;
    load(16'd10, 16'd4);
    @(negedge clk);
    key_n = 4'b1110;
    idle(DEB - 3);
    key_n = 4'hF;
    idle(GAP);
    check("R9 short glitch ignored", {ovf, led}, {1'b0, 16'd4});
    @(negedge clk);
    key_n = 4'b1110;
    idle(6 * GAP);
    check("R9 held once", {ovf, led}, {1'b0, 16'd6});
    key_n = 4'hF;
    idle(GAP);
  endtask

  task automatic t_collide;
    load(16'd10, 16'd3); press(4'b0011);
    check("R10 add beats sub", {ovf, led}, {1'b0, 16'd13});
    load(16'd100, 16'd50);
    sw = 16'd7; press(4'b1010);
    check("R10 op uses old operand", {ovf, led}, {1'b0, 16'd150});
    press(4'b0001);
    check("R10 capture still stored", {ovf, led}, {1'b1, 16'd65493});
  endtask

  initial begin
    t_reset;
    t_mirror;
    t_add;
    t_mul;
    t_sub;
    t_hold_and_return;
    t_glitch;
    t_collide;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule